// File: doc/BRIEF.md
# Two-Wire Sixteen-Byte Register Store

This block is a target on a two-wire open-drain serial bus, fronting a small store of sixteen 8-bit words held in flip-flops. A fast system clock samples the clock line and the data line through a synchroniser. From the sampled lines the block finds bus start and stop events and clock edges. It then shifts in a control byte and, for writes, a word address followed by one data byte. Each accepted byte is acknowledged by pulling the data line low. Read data leaves most significant bit first.

A host stores a byte with a single-byte write: start, control byte with direction 0, word address, data, stop. A random read first loads the internal pointer with a write header that carries no data. A repeated start and a control byte with direction 1 follow. Reads then keep streaming successive words until the host answers a byte with no acknowledge. After each completed write, a busy interval runs for a parameterised number of system clocks. During that interval the block refuses its control byte, which lets a host poll for completion.

Top module: `i2c_word_store`

## Requirements
- R1: After reset the data line is released (`sda_pull_low` = 0) and every one of the 16 words reads as 0x00.
- R2: A control byte is acknowledged only when its upper four bits, received first, are 1010. Its next three bits are ignored, and its last bit selects the direction (0 = write, 1 = read). Any other upper code is answered with no acknowledge.
- R3: A write transfer (start, control with direction 0, address, data, stop) stores the data at the word selected by the low four address bits. The upper four address bits are ignored.
- R4: A random read returns the word at the loaded address, most significant bit first. The read is a write header with an address, then a repeated start and a control byte with direction 1.
- R5: In a read, every byte that the host acknowledges is followed by the word at the next address, and the address wraps from 15 to 0.
- R6: When the host answers a read byte with no acknowledge, the block stops sending and leaves the data line released.
- R7: For BUSY_CYCLES system clocks after the stop that ends a write, a control byte is not acknowledged. After the interval it is acknowledged again.
- R8: A start seen partway through a byte aborts the transfer, and the block then takes the next byte as a control byte. A stop seen partway through a byte aborts the transfer to idle with no write.
- R9: The block pulls the data line low only for an acknowledge or a 0 data bit. It changes its drive only while the sampled clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_pull_low | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
The hardest states to reach from the ports are the aborts in the middle of a byte and the window in which the busy interval refuses the control byte. Both depend on bus events placed at exact bit counts. The bench's bit-level master can stop a byte after any number of bits. It then issues a start or a stop from that point. The bench also fires a control byte right after a write's stop, so that it lands inside a busy interval shortened by a parameter override, and retries once the interval has ended. Randomised writes and random reads over all sixteen addresses, together with a sequential read across the 15-to-0 wrap, are compared against a model array kept in the bench.

// File: rtl/i2c_word_store_pkg.sv
package i2c_word_store_pkg;

    // Device-type code expected in the upper nibble of the control byte
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,   // waiting for a start
        S_CTRL,   // shifting in the control byte
        S_CACK,   // acknowledging the control byte
        S_ADDR,   // shifting in the word address
        S_AACK,   // acknowledging the address
        S_WDATA,  // shifting in the write data
        S_WACK,   // acknowledging the write data
        S_HOLD,   // write done, ignore the rest until start/stop
        S_RDATA,  // shifting out a read byte
        S_MACK    // host acknowledge slot after a read byte
    } state_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic ctrl_matches(input logic [7:0] b);
        return b[7:4] == DEV_CODE;
    endfunction

    function automatic logic drives_low(input state_t s, input logic tx_msb);
        return (s == S_CACK) || (s == S_AACK) || (s == S_WACK) ||
               ((s == S_RDATA) && !tx_msb);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dprev
);
    // Each line idles high on an open-drain bus, so reset to 1
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
                last  <= chain[STAGES-1];
            end
        end
        assign dout[g]  = chain[STAGES-1];
        assign dprev[g] = last;
    end
endmodule

// File: rtl/i2c_store_array.sv
module i2c_store_array #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= 8'h00;
            else if (we && (waddr == AW'(g)))
                words[g] <= wdata;
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/i2c_busy_timer.sv
module i2c_busy_timer #(
    parameter int CYCLES = 300000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (go)
            left <= CW'(CYCLES);
        else if (left != '0)
            left <= left - CW'(1);
    end

    assign busy = (left != '0);
endmodule

// File: rtl/i2c_word_store.sv
module i2c_word_store
    import i2c_word_store_pkg::*;
#(
    parameter int DEPTH       = 16,      // power of two
    parameter int BUSY_CYCLES = 300000,  // write interval in clk cycles
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_low
);
    localparam int AW = $clog2(DEPTH);

    // Line sampling and event decode (bit 1 = clock, bit 0 = data)
    logic [1:0] lvl, prv;
    bus_ev_t    ev;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({scl_i, sda_i}),
        .dout  (lvl),
        .dprev (prv)
    );

    always_comb begin
        ev.sda      = lvl[0];
        ev.scl_rise = lvl[1] & ~prv[1];
        ev.scl_fall = ~lvl[1] & prv[1];
        ev.start    = lvl[1] & prv[1] & prv[0] & ~lvl[0];
        ev.stop     = lvl[1] & prv[1] & ~prv[0] & lvl[0];
    end

    // Protocol state
    state_t        state;
    logic [3:0]    cnt;
    logic [7:0]    shreg;
    logic [7:0]    txb;
    logic [AW-1:0] ptr;
    logic          mack;
    logic          wr_pend;
    logic          busy;
    logic          wr_en;
    logic          tmr_go;
    logic [7:0]    rd_data;
    logic [AW-1:0] ptr_inc;

    assign ptr_inc = ptr + AW'(1);
    assign wr_en   = (state == S_WDATA) && ev.scl_fall && (cnt == 4'd8);
    assign tmr_go  = ev.stop && wr_pend;

    i2c_store_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (ptr),
        .wdata (shreg),
        .raddr (ptr),
        .rdata (rd_data)
    );

    i2c_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (tmr_go),
        .busy (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cnt     <= 4'd0;
            shreg   <= 8'h00;
            txb     <= 8'hFF;
            ptr     <= '0;
            mack    <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            if (wr_en)
                wr_pend <= 1'b1;
            else if (tmr_go)
                wr_pend <= 1'b0;

            if (ev.stop) begin
                state <= S_IDLE;
                cnt   <= 4'd0;
            end else if (ev.start) begin
                state <= S_CTRL;
                cnt   <= 4'd0;
            end else begin
                case (state)
                    S_CTRL, S_ADDR, S_WDATA: begin
                        if (ev.scl_rise && (cnt != 4'd8)) begin
                            shreg <= {shreg[6:0], ev.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (ev.scl_fall && (cnt == 4'd8)) begin
                            cnt <= 4'd0;
                            if (state == S_CTRL)
                                state <= (ctrl_matches(shreg) && !busy) ? S_CACK : S_IDLE;
                            else if (state == S_ADDR)
                                state <= S_AACK;
                            else
                                state <= S_WACK;
                        end
                    end
                    S_CACK: begin
                        if (ev.scl_fall) begin
                            if (shreg[0]) begin
                                state <= S_RDATA;
                                txb   <= rd_data;
                                ptr   <= ptr_inc;
                            end else begin
                                state <= S_ADDR;
                            end
                        end
                    end
                    S_AACK: begin
                        if (ev.scl_fall) begin
                            ptr   <= shreg[AW-1:0];
                            state <= S_WDATA;
                        end
                    end
                    S_WACK: begin
                        if (ev.scl_fall)
                            state <= S_HOLD;
                    end
                    S_RDATA: begin
                        if (ev.scl_fall) begin
                            if (cnt == 4'd7) begin
                                state <= S_MACK;
                                cnt   <= 4'd0;
                            end else begin
                                txb <= {txb[6:0], 1'b1};
                                cnt <= cnt + 4'd1;
                            end
                        end
                    end
                    S_MACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                state <= S_RDATA;
                                txb   <= rd_data;
                                ptr   <= ptr_inc;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_low = drives_low(state, txb[7]);

endmodule

// File: rtl/i2c_word_store_chk.sv
module i2c_word_store_chk
    import i2c_word_store_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sda_low,
    input logic       scl_lvl,
    input state_t     state,
    input logic [7:0] shreg,
    input logic       busy,
    input logic       ev_start,
    input logic       ev_stop,
    input logic       wr_en
);
    assert_drive_change_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> !$past(scl_lvl));

    assert_ack_needs_code_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_CACK) |-> ctrl_matches(shreg));

    assert_no_ack_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(state == S_CACK) |-> !$past(busy));

    assert_start_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (state == S_CTRL));

    assert_stop_idles_R8: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (state == S_IDLE));

    assert_write_acked_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (state == S_WACK));
endmodule

bind i2c_word_store i2c_word_store_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_low  (sda_pull_low),
    .scl_lvl  (lvl[1]),
    .state    (state),
    .shreg    (shreg),
    .busy     (busy),
    .ev_start (ev.start),
    .ev_stop  (ev.stop),
    .wr_en    (wr_en)
);

// File: tb/i2c_word_store_tb.sv
module i2c_word_store_tb;
    localparam int BUSY = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_low;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_low;

    always #5 clk = ~clk;

    i2c_word_store #(.DEPTH(16), .BUSY_CYCLES(BUSY)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl),
        .sda_i        (sda_bus),
        .sda_pull_low (sda_low)
    );

    int total = 0;
    int bad   = 0;
    logic [7:0] model [16];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q();
        scl = 1'b1;   q();
        sda_m = 1'b0; q();
        scl = 1'b0;   q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q();
        scl = 1'b1;   q();
        sda_m = 1'b1; q();
    endtask

    // Send the n leading bits of v; flags any bit where the bus differs (R9)
    task automatic send_bits(input logic [7:0] v, input int n, output logic clash);
        clash = 1'b0;
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = v[i]; q();
            scl = 1'b1;   q();
            if (sda_bus !== v[i]) clash = 1'b1;
            q();
            scl = 1'b0;   q();
        end
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic clash;
        send_bits(v, 8, clash);
        check("R9 bus follows host bits", {31'd0, clash}, 32'd0);
        sda_m = 1'b1; q();
        scl = 1'b1;   q();
        ack = (sda_bus == 1'b0);
        q();
        scl = 1'b0;   q();
    endtask

    task automatic get_byte(input logic host_ack, output logic [7:0] d);
        sda_m = 1'b1;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            q();
            scl = 1'b1; q();
            d = {d[6:0], sda_bus};
            q();
            scl = 1'b0;
        end
        sda_m = host_ack ? 1'b0 : 1'b1; q();
        scl = 1'b1; q(); q();
        scl = 1'b0; q();
        sda_m = 1'b1;
    endtask

    task automatic write_mem(input logic [7:0] a, input logic [7:0] d, input bit wait_done);
        logic ack;
        bus_start();
        put_byte(8'hA0, ack); check("R3 control ack", {31'd0, ack}, 32'd1);
        put_byte(a, ack);     check("R3 address ack", {31'd0, ack}, 32'd1);
        put_byte(d, ack);     check("R3 data ack", {31'd0, ack}, 32'd1);
        bus_stop();
        model[a[3:0]] = d;
        if (wait_done) repeat (BUSY + 100) @(negedge clk);
    endtask

    task automatic read_rand(input logic [7:0] a, output logic [7:0] d);
        logic ack;
        bus_start();
        put_byte(8'hA0, ack);
        put_byte(a, ack);
        bus_start();
        put_byte(8'hA1, ack); check("R4 read control ack", {31'd0, ack}, 32'd1);
        get_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic ack;
        logic clash;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: released line and cleared store
        check("R1 sda released after reset", {31'd0, sda_low}, 32'd0);
        read_rand(8'h05, d);
        check("R1 word 5 after reset", {24'd0, d}, 32'h00);

        // R2: device code match, don't-care bits
        bus_start();
        put_byte(8'hB0, ack);
        check("R2 wrong code nack", {31'd0, ack}, 32'd0);
        bus_stop();
        bus_start();
        put_byte(8'hAE, ack);
        check("R2 don't-care bits ack", {31'd0, ack}, 32'd1);
        bus_stop();

        // R3: upper address bits ignored
        write_mem(8'h3A, 8'h5C, 1'b1);
        read_rand(8'h0A, d);
        check("R3 write lands at low nibble", {24'd0, d}, 32'h5C);

        // R7: poll during the busy interval
        write_mem(8'h03, 8'h11, 1'b0);
        bus_start();
        put_byte(8'hA0, ack);
        check("R7 nack while busy", {31'd0, ack}, 32'd0);
        bus_stop();
        repeat (BUSY + 100) @(negedge clk);
        bus_start();
        put_byte(8'hA0, ack);
        check("R7 ack after interval", {31'd0, ack}, 32'd1);
        bus_stop();

        // R4: random writes and random reads against the model
        for (int k = 0; k < 8; k++) begin
            logic [7:0] a;
            logic [7:0] v;
            a = 8'($urandom);
            v = 8'($urandom);
            write_mem(a, v, 1'b1);
            read_rand(a, d);
            check("R4 random read", {24'd0, d}, {24'd0, model[a[3:0]]});
        end

        // R5 and R6: sequential read across the wrap, then host NACK
        write_mem(8'h0E, 8'h21, 1'b1);
        write_mem(8'h0F, 8'hC2, 1'b1);
        write_mem(8'h00, 8'h63, 1'b1);
        write_mem(8'h01, 8'h05, 1'b1);
        bus_start();
        put_byte(8'hA0, ack);
        put_byte(8'h0E, ack);
        bus_start();
        put_byte(8'hA1, ack);
        get_byte(1'b1, d); check("R5 seq byte at 14", {24'd0, d}, {24'd0, model[14]});
        get_byte(1'b1, d); check("R5 seq byte at 15", {24'd0, d}, {24'd0, model[15]});
        get_byte(1'b0, d); check("R5 seq wrap to 0", {24'd0, d}, {24'd0, model[0]});
        scl = 1'b1; q();
        check("R6 line released after nack", {31'd0, sda_bus}, 32'd1);
        scl = 1'b0; q();
        bus_stop();

        // R8: start partway through a byte
        bus_start();
        send_bits(8'hA0, 4, clash);
        bus_start();
        put_byte(8'hA0, ack);
        check("R8 control after mid-byte start", {31'd0, ack}, 32'd1);
        put_byte(8'h07, ack);
        put_byte(8'h77, ack);
        bus_stop();
        model[7] = 8'h77;
        repeat (BUSY + 100) @(negedge clk);
        read_rand(8'h07, d);
        check("R8 write after restart", {24'd0, d}, 32'h77);

        // R8: stop partway through the data byte
        bus_start();
        put_byte(8'hA0, ack);
        put_byte(8'h07, ack);
        send_bits(8'h99, 5, clash);
        bus_stop();
        bus_start();
        put_byte(8'hA0, ack);
        check("R8 no busy after aborted write", {31'd0, ack}, 32'd1);
        bus_stop();
        read_rand(8'h07, d);
        check("R8 aborted write leaves word", {24'd0, d}, 32'h77);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule